// File: doc/BRIEF.md
# Multi-Client Binary Lock Semaphore

This block is a hardware binary semaphore shared by a parameterized number of client processes. It keeps one bit of state: held or free. A client acquires it with a blocking request/acknowledge handshake. The client raises its request line and keeps it high. The block pulses that client's acknowledge in a cycle where the semaphore can be granted, and the grant takes the lock.

Any client, including one that does not hold the lock, can release it with a one-cycle post strobe. The post takes effect at once and never stalls the poster. The semaphore never counts. Extra posts on a free semaphore are absorbed, so exactly one later request is granted before the next post is needed.

When several clients wait at once, the lowest-indexed requester wins. A post that coincides with a pending request passes ownership straight to that requester, with no free cycle in between.

Top module: `shared_lock_sem`

## Requirements
- R1: After reset the semaphore is free (`semLocked` = 0) and no acknowledge is asserted.
- R2: When the semaphore is free, or any post strobe is high, and at least one request is high, exactly one acknowledge is high in that same cycle. It goes to the requester with the lowest index (bit 0 has the highest priority).
- R3: A cycle with an acknowledge leaves the semaphore held (`semLocked` = 1) in the next cycle.
- R4: While the semaphore is held and no post strobe is high, no acknowledge is given and the semaphore stays held in the next cycle.
- R5: A post strobe in a cycle with no acknowledge leaves the semaphore free in the next cycle.
- R6: A post in the same cycle as a pending request grants that request at once, and `semLocked` stays 1 across the handover.
- R7: Posts while the semaphore is already free are not counted. After any number of them, one grant locks the semaphore, and the next request waits for a new post.
- R8: A post from any client releases the semaphore, whether or not that client holds it.
- R9: An acknowledge is only ever given to a client whose request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| waitReq | input | NUM_CLIENTS | Per-client wait request, held until acknowledged |
| postStb | input | NUM_CLIENTS | Per-client one-cycle release strobe |
| waitAck | output | NUM_CLIENTS | Per-client wait acknowledge, combinational from the current requests and lock state |
| semLocked | output | 1 | Current lock state, 1 = held |

## Verification
Random request and post patterns with a fixed seed put many clients in contention. This separates a correct lowest-index arbiter from one that favours another index or grants twice. Directed sequences check the rest. A post meeting a waiting request shows whether the handover leaves a free cycle. Repeated posts on a free semaphore, followed by two requests, show whether the posts are wrongly counted. A post from a client that does not own the lock shows whether release is tied to ownership. A held semaphore with requests and no post shows whether the block leaks a grant.

// File: rtl/shared_lock_pkg.sv
package shared_lock_pkg;
  localparam int MAX_CLIENTS = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic                   takeLock;
    logic                   dropLock;
    logic [MAX_CLIENTS-1:0] grantVec;
  } lockCtrl_t;
endpackage

// File: rtl/shared_lock_ctrl.sv
module shared_lock_ctrl
  import shared_lock_pkg::*;
#(
  parameter int NUM_CLIENTS = 4
) (
  input  logic [NUM_CLIENTS-1:0] waitReq,
  input  logic [NUM_CLIENTS-1:0] postStb,
  input  logic                   lockState,
  output lockCtrl_t              ctrlOut
);
  logic                   anyPost;
  logic                   grantOpen;
  logic [NUM_CLIENTS-1:0] pick;
  logic                   found;

  assign anyPost   = |postStb;
  assign grantOpen = !lockState || anyPost;

  // lowest index wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (waitReq[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    ctrlOut          = '0;
    ctrlOut.takeLock = grantOpen && found;
    ctrlOut.dropLock = anyPost && !(grantOpen && found);
    if (grantOpen) ctrlOut.grantVec[NUM_CLIENTS-1:0] = pick;
  end
endmodule

// File: rtl/shared_lock_dp.sv
module shared_lock_dp
  import shared_lock_pkg::*;
#(
  parameter int NUM_CLIENTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lockCtrl_t              ctrlIn,
  output logic                   lockState,
  output logic [NUM_CLIENTS-1:0] ackOut
);
  always_ff @(posedge clk) begin
    if (!rst_n)               lockState <= 1'b0;
    else if (ctrlIn.takeLock) lockState <= 1'b1;
    else if (ctrlIn.dropLock) lockState <= 1'b0;
  end

  assign ackOut = ctrlIn.grantVec[NUM_CLIENTS-1:0];
endmodule

// File: rtl/shared_lock_sem.sv
module shared_lock_sem
  import shared_lock_pkg::*;
#(
  parameter int NUM_CLIENTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] waitReq,
  input  logic [NUM_CLIENTS-1:0] postStb,
  output logic [NUM_CLIENTS-1:0] waitAck,
  output logic                   semLocked
);
  lockCtrl_t ctrlBus;
  logic      lockState;

  shared_lock_ctrl #(.NUM_CLIENTS(NUM_CLIENTS)) ctrl_i (
    .waitReq  (waitReq),
    .postStb  (postStb),
    .lockState(lockState),
    .ctrlOut  (ctrlBus)
  );

  shared_lock_dp #(.NUM_CLIENTS(NUM_CLIENTS)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrlIn   (ctrlBus),
    .lockState(lockState),
    .ackOut   (waitAck)
  );

  assign semLocked = lockState;
endmodule

// File: rtl/shared_lock_sem_chk.sv
module shared_lock_sem_chk #(
  parameter int NUM_CLIENTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CLIENTS-1:0] waitReq,
  input logic [NUM_CLIENTS-1:0] postStb,
  input logic [NUM_CLIENTS-1:0] waitAck,
  input logic                   semLocked
);
  assert_single_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(waitAck));

  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|waitAck) |-> (((waitAck - 1'b1) & waitReq) == '0));

  assert_free_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!semLocked || (|postStb)) && (|waitReq)) |-> (|waitAck));

  assert_grant_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|waitAck) |=> semLocked);

  assert_held_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (semLocked && !(|postStb)) |-> (waitAck == '0));

  assert_held_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (semLocked && !(|postStb)) |=> semLocked);

  assert_post_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|postStb) && !(|waitAck)) |=> !semLocked);

  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((waitAck & ~waitReq) == '0));
endmodule

bind shared_lock_sem shared_lock_sem_chk #(.NUM_CLIENTS(NUM_CLIENTS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .waitReq  (waitReq),
  .postStb  (postStb),
  .waitAck  (waitAck),
  .semLocked(semLocked)
);

// File: tb/shared_lock_sem_tb_top.sv
module shared_lock_sem_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] waitReq = '0;
  logic [N-1:0] postStb = '0;
  logic [N-1:0] waitAck;
  logic         semLocked;

  int  nChecks = 0;
  int  nFails = 0;
  bit  expLocked = 1'b0;
  bit  doneFlag = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  shared_lock_sem #(.NUM_CLIENTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .waitReq(waitReq), .postStb(postStb),
    .waitAck(waitAck), .semLocked(semLocked)
  );

  function automatic logic [N-1:0] expAck(logic [N-1:0] rq, logic [N-1:0] ps, bit lk);
    logic [N-1:0] r = '0;
    if (!lk || (ps != '0)) begin
      for (int i = 0; i < N; i++) begin
        if (rq[i]) begin
          r[i] = 1'b1;
          break;
        end
      end
    end
    return r;
  endfunction

  function automatic bit nextLock(logic [N-1:0] rq, logic [N-1:0] ps, bit lk);
    if (expAck(rq, ps, lk) != '0) return 1'b1;
    if (ps != '0) return 1'b0;
    return lk;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, check mid-low phase, advance model at posedge
  task automatic step(logic [N-1:0] rq, logic [N-1:0] ps, string tag);
    waitReq = rq;
    postStb = ps;
    #2;
    chk({tag, " ack"}, 32'(waitAck), 32'(expAck(rq, ps, expLocked)));
    chk({tag, " lock"}, 32'(semLocked), 32'(expLocked));
    @(posedge clk);
    expLocked = nextLock(rq, ps, expLocked);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 lock", 32'(semLocked), 32'd0);
    chk("R1 ack", 32'(waitAck), 32'd0);
    @(negedge clk);

    // R2 contention on free semaphore: lowest wins, R3 lock follows
    step(4'b1110, 4'b0000, "R2 contend");
    chk("R3 locked", 32'(semLocked), 32'd1);
    // R4 held: requests blocked
    step(4'b1100, 4'b0000, "R4 blocked");
    step(4'b1100, 4'b0000, "R4 blocked2");
    // R6 and R8 post by non-owner client 0 with waiting requests: direct handover
    step(4'b1100, 4'b0001, "R6 handover R8");
    chk("R6 no gap", 32'(semLocked), 32'd1);
    // R5 post with no request frees
    step(4'b1000, 4'b0000, "R4 still held");
    step(4'b0000, 4'b1000, "R5 release");
    chk("R5 free", 32'(semLocked), 32'd0);
    // R7 extra posts while free are not counted
    step(4'b0000, 4'b0110, "R7 post free");
    step(4'b0000, 4'b0001, "R7 post free2");
    step(4'b0100, 4'b0000, "R7 first grant");
    step(4'b0010, 4'b0000, "R7 second waits");
    chk("R7 still held", 32'(semLocked), 32'd1);
    step(4'b0000, 4'b0010, "R5 release2");

    // constrained random: requests and rarer posts, R9 covered by ack vs req
    for (int k = 0; k < 2000; k++) begin
      logic [N-1:0] rq;
      logic [N-1:0] ps;
      rq = N'($urandom);
      ps = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
      step(rq, ps, "R2 R9 random");
    end

    // reset again mid-run, R1
    step(4'b0001, 4'b0000, "R3 pre-reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    expLocked = 1'b0;
    waitReq = '0;
    #2;
    chk("R1 relock", 32'(semLocked), 32'd0);
    @(negedge clk);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule